// File: doc/BRIEF.md
# Three-Level Nested Interrupt Priority Controller

This block sits between a set of interrupt request sources and a CPU core. Eighteen request lines are folded onto ten vectors. Each vector carries one level-select bit that picks one of two levels open to that vector. Every cycle the controller compares the pending vectors against the level the CPU is currently servicing. It picks one winner, then presents that vector's address, its level and a one-cycle accept strobe on registered outputs.

Three levels exist: low, high and top. The first two vectors may run at top or low level; the other eight at high or low. A three-bit in-service record holds one bit per level and tracks how deeply handlers are nested. A return pulse from the CPU frees the highest level in service. Request lines are level-held by their sources: a blocked request is never dropped and is taken as soon as its level becomes eligible. A global enable gates every acceptance.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `irq_ack`, `irq_vec`, `irq_lvl` and `in_svc` are all zero until the first acceptance.
- R2: Source i for i < 10 feeds vector i, and source i for i >= 10 feeds vector i-8. The vector address of vector n is 3 + 8·n (vector 0 = 0x0003, vector 9 = 0x004B).
- R3: Level codes are low = 0, high = 1, top = 2. `lvl_hi[n]` = 1 gives level top for vectors 0 and 1 and level high for vectors 2 to 9. `lvl_hi[n]` = 0 gives level low. Bit k of `in_svc` marks level k in service.
- R4: When pending vectors have different levels, the one with the highest level is accepted.
- R5: Among eligible pending vectors of the same level, the lowest vector index (smallest address) is accepted.
- R6: A request whose level is equal to or below the highest level set in `in_svc` is not accepted. It stays pending and is accepted once that level is freed.
- R7: While `glob_en` is 0, nothing is accepted, whatever requests are pending.
- R8: An acceptance decided from the inputs of one cycle shows on the next clock edge. It pulses `irq_ack` for one cycle and updates `irq_vec` and `irq_lvl`, which hold their value until the next acceptance. On that same edge it sets the accepted level's bit in `in_svc`.
- R9: A `reti` pulse clears the highest set bit of `in_svc`. With `in_svc` empty it has no effect.
- R10: When `reti` and arbitration fall in the same cycle, the level freed by the return is already eligible in that cycle's arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | 18 | Level-held request lines from the sources |
| lvl_hi | input | 10 | Per-vector level select (1 = upper allowed level, 0 = low) |
| glob_en | input | 1 | Global acceptance enable |
| reti | input | 1 | One-cycle return-from-handler pulse |
| irq_ack | output | 1 | One-cycle accept strobe |
| irq_vec | output | 16 | Address of the accepted vector |
| irq_lvl | output | 2 | Level code of the accepted vector |
| in_svc | output | 3 | In-service record, one bit per level |

## Verification
The sharpest overlap is a return pulse arriving in the same cycle as a pending request at the level being returned from. The bench provokes it by clearing the winning source while a second request of the same level waits, and then pulsing `reti`. It judges the case by requiring the waiting vector's strobe on the very next edge, with `in_svc` showing the level re-taken rather than freed. A second overlap is a higher-level request accepted on the edge right after a lower one, which nests without a gap. Both are compared every cycle against a behavioural model of the level record.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    LV_LOW  = 2'd0,
    LV_HIGH = 2'd1,
    LV_TOP  = 2'd2
  } lvl_e;

  localparam int unsigned NUM_LVL = 3;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_pkg::*; #(
  parameter int unsigned NUM_VEC     = 10,
  parameter int unsigned NUM_SRC     = 18,
  parameter int unsigned NUM_TOP_VEC = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_VEC),
  localparam int unsigned FOLD       = NUM_SRC - NUM_VEC
) (
  input  logic [NUM_SRC-1:0]  src,
  input  logic [NUM_VEC-1:0]  lvl_hi,
  input  logic                glob_en,
  input  logic [NUM_LVL-1:0]  svc_eff,
  output logic                grant,
  output logic [IDX_W-1:0]    win_idx,
  output lvl_e                win_lvl
);
  logic [NUM_VEC-1:0] vec_req;
  lvl_e               vec_lvl [NUM_VEC];
  logic [1:0]         bar;

  // Fold sources onto vectors, and derive each vector's level
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    if (v >= NUM_VEC - FOLD) begin : g_fold
      assign vec_req[v] = src[v] | src[v + FOLD];
    end else begin : g_single
      assign vec_req[v] = src[v];
    end
    if (v < NUM_TOP_VEC) begin : g_top
      assign vec_lvl[v] = lvl_hi[v] ? LV_TOP : LV_LOW;
    end else begin : g_mid
      assign vec_lvl[v] = lvl_hi[v] ? LV_HIGH : LV_LOW;
    end
  end

  // Minimum level a request must reach: one above the highest in service
  always_comb begin
    if (svc_eff[2])      bar = 2'd3;
    else if (svc_eff[1]) bar = 2'd2;
    else if (svc_eff[0]) bar = 2'd1;
    else                 bar = 2'd0;
  end

  // Highest level wins; strict compare keeps the lowest index on ties
  always_comb begin
    grant   = 1'b0;
    win_idx = '0;
    win_lvl = LV_LOW;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (glob_en && vec_req[v] && (2'(vec_lvl[v]) >= bar) &&
          (!grant || (vec_lvl[v] > win_lvl))) begin
        grant   = 1'b1;
        win_idx = IDX_W'(v);
        win_lvl = vec_lvl[v];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack import irq_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reti,
  input  logic               grant,
  input  lvl_e               grant_lvl,
  output logic [NUM_LVL-1:0] svc_q,
  output logic [NUM_LVL-1:0] svc_eff
);
  logic [NUM_LVL-1:0] svc_nx;
  logic               cleared;

  // Return is applied before arbitration sees the record
  always_comb begin
    svc_eff = svc_q;
    cleared = 1'b0;
    if (reti) begin
      for (int k = NUM_LVL - 1; k >= 0; k--) begin
        if (!cleared && svc_q[k]) begin
          svc_eff[k] = 1'b0;
          cleared    = 1'b1;
        end
      end
    end
  end

  always_comb begin
    svc_nx = svc_eff;
    if (grant) svc_nx = svc_eff | (NUM_LVL'(1) << grant_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_nx;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl import irq_pkg::*; #(
  parameter int unsigned NUM_VEC     = 10,
  parameter int unsigned NUM_SRC     = 18,
  parameter int unsigned NUM_TOP_VEC = 2,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned VEC_BASE    = 3,
  parameter int unsigned VEC_STRIDE  = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [NUM_VEC-1:0] lvl_hi,
  input  logic               glob_en,
  input  logic               reti,
  output logic               irq_ack,
  output logic [ADDR_W-1:0]  irq_vec,
  output logic [1:0]         irq_lvl,
  output logic [NUM_LVL-1:0] in_svc
);
  logic               rst_sync_n;
  logic               grant;
  logic [IDX_W-1:0]   win_idx;
  lvl_e               win_lvl;
  logic [NUM_LVL-1:0] svc_eff;
  logic [ADDR_W-1:0]  vec_nx;
  logic               ack_q;
  logic [ADDR_W-1:0]  vec_q;
  lvl_e               lvl_q;

  irq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  irq_arbiter #(
    .NUM_VEC     (NUM_VEC),
    .NUM_SRC     (NUM_SRC),
    .NUM_TOP_VEC (NUM_TOP_VEC)
  ) u_arb (
    .src     (irq_src),
    .lvl_hi  (lvl_hi),
    .glob_en (glob_en),
    .svc_eff (svc_eff),
    .grant   (grant),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  irq_nest_stack u_stk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reti      (reti),
    .grant     (grant),
    .grant_lvl (win_lvl),
    .svc_q     (in_svc),
    .svc_eff   (svc_eff)
  );

  always_comb begin
    vec_nx = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(win_idx);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ack_q <= 1'b0;
    else             ack_q <= grant;
  end

  // Vector and level registers load only on acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q <= '0;
      lvl_q <= LV_LOW;
    end else if (grant) begin
      vec_q <= vec_nx;
      lvl_q <= win_lvl;
    end
  end

  assign irq_ack = ack_q;
  assign irq_vec = vec_q;
  assign irq_lvl = lvl_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NUM_TOP_VEC = 2,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned VEC_BASE    = 3,
  parameter int unsigned VEC_STRIDE  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_en,
  input logic              irq_ack,
  input logic [ADDR_W-1:0] irq_vec,
  input logic [1:0]        irq_lvl,
  input logic [2:0]        in_svc
);
  localparam logic [ADDR_W-1:0] TOP_END = ADDR_W'(VEC_BASE + VEC_STRIDE * NUM_TOP_VEC);

  assert_vec_on_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ((irq_vec - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STRIDE)) == '0);

  assert_top_only_low_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_lvl == 2'd2) |-> (irq_vec < TOP_END));

  assert_lvl_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_lvl != 2'd3));

  assert_ack_top_of_stack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ((in_svc >> irq_lvl) == 3'b001));

  assert_no_ack_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(glob_en) |-> !irq_ack);

  assert_one_new_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_svc & ~$past(in_svc)) <= 1);

  assert_new_level_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_svc & ~$past(in_svc))) |-> irq_ack);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NUM_TOP_VEC (NUM_TOP_VEC),
  .ADDR_W      (ADDR_W),
  .VEC_BASE    (VEC_BASE),
  .VEC_STRIDE  (VEC_STRIDE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .glob_en (glob_en),
  .irq_ack (irq_ack),
  .irq_vec (irq_vec),
  .irq_lvl (irq_lvl),
  .in_svc  (in_svc)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] irq_src = '0;
  logic [9:0]  lvl_hi = '0;
  logic        glob_en = 1'b0;
  logic        reti = 1'b0;
  logic        irq_ack;
  logic [15:0] irq_vec;
  logic [1:0]  irq_lvl;
  logic [2:0]  in_svc;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int m_svc = 0;
  int e_ack = 0;
  int e_vec = 0;
  int e_lvl = 0;

  irq_prio_ctrl u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_src (irq_src),
    .lvl_hi  (lvl_hi),
    .glob_en (glob_en),
    .reti    (reti),
    .irq_ack (irq_ack),
    .irq_vec (irq_vec),
    .irq_lvl (irq_lvl),
    .in_svc  (in_svc)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: model the edge from current inputs, then compare outputs
  task automatic cyc(input string tag);
    int svc;
    int bar;
    int best;
    int blvl;
    int lv;
    bit cleared;
    bit r;
    svc = m_svc;
    cleared = 0;
    if (reti) begin
      for (int k = 2; k >= 0; k--) begin
        if (!cleared && svc[k]) begin
          svc[k] = 1'b0;
          cleared = 1;
        end
      end
    end
    bar = svc[2] ? 3 : (svc[1] ? 2 : (svc[0] ? 1 : 0));
    best = -1;
    blvl = -1;
    for (int v = 0; v < 10; v++) begin
      r = irq_src[v] || (v >= 2 && irq_src[v+8]);
      lv = lvl_hi[v] ? ((v < 2) ? 2 : 1) : 0;
      if (glob_en && r && lv >= bar && lv > blvl) begin
        best = v;
        blvl = lv;
      end
    end
    e_ack = (best >= 0) ? 1 : 0;
    if (best >= 0) begin
      e_vec = 3 + 8 * best;
      e_lvl = blvl;
      svc = svc | (1 << blvl);
    end
    m_svc = svc;
    @(posedge clk);
    #(CLK_PER/4);
    check({tag, " ack"}, int'(irq_ack), e_ack);
    check({tag, " vec"}, int'(irq_vec), e_vec);
    check({tag, " lvl"}, int'(irq_lvl), e_lvl);
    check({tag, " svc"}, int'(in_svc), m_svc);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PER/4);
    // R1: outputs during reset
    check("R1 ack in reset", int'(irq_ack), 0);
    check("R1 svc in reset", int'(in_svc), 0);
    rst_n = 1'b1;
    repeat (3) cyc("R1 idle");

    // R2: folded source 12 lands on vector 4, address 35
    glob_en = 1'b1;
    irq_src[12] = 1'b1;
    cyc("R2 fold");
    check("R2 addr of vec4", int'(irq_vec), 35);
    irq_src[12] = 1'b0;
    cyc("R8 single pulse");
    check("R8 strobe one cycle", int'(irq_ack), 0);
    reti = 1'b1;
    cyc("R9 pop low");
    reti = 1'b0;
    check("R9 empty after pop", int'(in_svc), 0);

    // R5 and R10: two low requests, lowest index first
    irq_src[7] = 1'b1;
    irq_src[3] = 1'b1;
    cyc("R5 tie");
    check("R5 vec3 wins", int'(irq_vec), 27);
    irq_src[3] = 1'b0;
    cyc("R6 low blocked");
    check("R6 no ack same level", int'(irq_ack), 0);
    reti = 1'b1;
    cyc("R10 reti and grant");
    reti = 1'b0;
    check("R10 vec7 taken on return", int'(irq_vec), 59);
    check("R10 low re-taken", int'(in_svc), 1);
    irq_src[7] = 1'b0;
    reti = 1'b1;
    cyc("R9 pop");
    reti = 1'b0;

    // R4: high level beats a lower-index low request
    lvl_hi[8] = 1'b1;
    irq_src[1] = 1'b1;
    irq_src[16] = 1'b1;
    cyc("R4 level wins");
    check("R4 vec8 chosen", int'(irq_vec), 67);
    check("R3 high code", int'(irq_lvl), 1);
    irq_src[16] = 1'b0;
    cyc("R6 low under high");
    reti = 1'b1;
    cyc("R10 low after high");
    reti = 1'b0;
    irq_src[1] = 1'b0;
    reti = 1'b1;
    cyc("R9 pop");
    reti = 1'b0;

    // R3 nesting: low, then high, then top; top repeat blocked
    lvl_hi[0] = 1'b1;
    irq_src[9] = 1'b1;
    cyc("R3 low in");
    irq_src[8] = 1'b1;
    cyc("R3 high nests");
    irq_src[0] = 1'b1;
    cyc("R3 top nests");
    check("R3 top code", int'(irq_lvl), 2);
    check("R3 all levels", int'(in_svc), 7);
    cyc("R6 top blocked");
    irq_src[0] = 1'b0;
    irq_src[8] = 1'b0;
    irq_src[9] = 1'b0;
    reti = 1'b1;
    cyc("R9 pop top");
    check("R9 top cleared", int'(in_svc), 3);
    cyc("R9 pop high");
    cyc("R9 pop low");
    cyc("R9 reti on empty");
    reti = 1'b0;
    check("R9 empty stays empty", int'(in_svc), 0);

    // R7: disabled acceptance, then enable
    glob_en = 1'b0;
    irq_src[5] = 1'b1;
    irq_src[13] = 1'b1;
    cyc("R7 disabled");
    cyc("R7 disabled");
    check("R7 no ack", int'(irq_ack), 0);
    glob_en = 1'b1;
    cyc("R7 enabled");
    check("R7 vec5 after enable", int'(irq_vec), 43);
    irq_src = '0;
    reti = 1'b1;
    cyc("R9 final pop");
    reti = 1'b0;
    cyc("R1 quiet");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule